// File: doc/BRIEF.md
# Lock-Step Graph Iteration Sequencer

This block is the central sequencer for an array of graph processing engines. A host starts a query with a step count. The sequencer first issues one global broadcast command, which an operation code and an engine selection mask qualify. It then drives the engines through that many propagation steps. Each step is a receive phase, a barrier, an update phase and a send phase. The send phase of one step is fused with the receive phase of the next, so only the last step has a send phase of its own.

The barrier closes a receive phase only after every engine has reported completion of that phase and the message network has reported itself empty. Completion reports are one-cycle pulses that are collected from the start of the phase, so an engine may report early and then go quiet. At every receive barrier, each engine's 16-bit contribution is folded into a single value with the operator the host chose at start. That value is then presented with a one-cycle valid strobe. The host sees a busy flag and the current step number, and a start request made while busy has no effect.

Top module: `graph_step_ctrl`

## Requirements
- R1: Phase codes on `phase_cmd` are idle=0, broadcast=1, receive=2, update=3, send+receive=4, send=5. An accepted start leads to broadcast. Step 1 opens with receive, and every later step opens with send+receive. Each receive or send+receive phase is followed by update. After the update of the last step comes send, and then idle.
- R2: A receive, send+receive or send phase ends on the clock edge after the first cycle in which every engine has pulsed `eng_done` at least once since the phase began and `net_empty` is high. A pulse that arrives without `net_empty` is kept.
- R3: An update phase ends on the edge after every engine has pulsed `eng_done` since the phase began, whatever the value of `net_empty`.
- R4: During broadcast, `bcast_op` and `bcast_sel` hold the values latched at start. Only the engines whose bit is set in `bcast_sel` must pulse `eng_done` to end the phase.
- R5: At each receive or send+receive barrier, the engine values (engine i at bits [16i+15:16i]) are combined into `red_result` with the start-time operator (0 = unsigned maximum, 1 = bitwise OR). `red_valid` is high for exactly the one cycle after the barrier cycle and is low at all other times.
- R6: `step_no` is 0 during broadcast and k during step k. A step count of 0 ends the query right after broadcast.
- R7: `busy` is high from the edge that accepts start until the query ends. A start request while busy is ignored, and the query keeps its original step count.
- R8: `cmd_stb` is high in the first cycle of every non-idle phase and is low in all other cycles.
- R9: `query_done` is high for one cycle, the first idle cycle after a query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Host query start request |
| step_count | input | STEP_W | Number of propagation steps |
| red_op | input | 1 | Reduce operator: 0 max, 1 OR |
| bcast_op_in | input | OPC_W | Operation code for the broadcast |
| bcast_sel_in | input | N_ENG | Engines targeted by the broadcast |
| eng_done | input | N_ENG | Per-engine phase completion pulse |
| net_empty | input | 1 | Message network holds no messages |
| eng_red_val | input | N_ENG*RED_W | Per-engine reduce contributions |
| phase_cmd | output | 3 | Current phase code |
| cmd_stb | output | 1 | First cycle of a new phase |
| bcast_op | output | OPC_W | Latched broadcast operation code |
| bcast_sel | output | N_ENG | Latched broadcast engine mask |
| busy | output | 1 | Query in progress |
| step_no | output | STEP_W | Current step number |
| red_result | output | RED_W | Combined reduce value |
| red_valid | output | 1 | Reduce value strobe |
| query_done | output | 1 | Query finished strobe |

## Verification
Every phase change lands one edge after the cycle that satisfies it. The bench drives done pulses and `net_empty` at a falling edge and expects the new phase, `cmd_stb`, `step_no` and `red_valid` at the next falling edge. `red_valid` must drop again one cycle later. `query_done` and the fall of `busy` are checked at the falling edge after the send barrier, and `query_done` is checked low one cycle after that. Held phases are checked at the same points, with partial done sets or with `net_empty` low, to confirm that nothing moved.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_BCAST    = 3'd1,
        PH_RECV     = 3'd2,
        PH_UPDATE   = 3'd3,
        PH_SENDRECV = 3'd4,
        PH_SEND     = 3'd5
    } phase_e;

    typedef enum logic {
        RED_MAX = 1'b0,
        RED_OR  = 1'b1
    } red_op_e;

    localparam int GSC_RED_W = 16;

    // phases closed by the full barrier (engines done and network drained)
    function automatic logic needs_drain(input phase_e ph);
        return (ph == PH_RECV) || (ph == PH_SENDRECV) || (ph == PH_SEND);
    endfunction

    // phases whose barrier also samples the reduce contributions
    function automatic logic is_rx_phase(input phase_e ph);
        return (ph == PH_RECV) || (ph == PH_SENDRECV);
    endfunction

endpackage

// File: rtl/gsc_done_collect.sv
module gsc_done_collect #(
    parameter int N_ENG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [N_ENG-1:0] preset,
    input  logic [N_ENG-1:0] eng_done,
    input  logic             net_empty,
    output logic             all_done,
    output logic             barrier
);

    logic [N_ENG-1:0] seen_q;
    logic [N_ENG-1:0] seen_now;

    assign seen_now = seen_q | eng_done;
    assign all_done = &seen_now;
    assign barrier  = all_done & net_empty;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (clr)
            seen_q <= preset;
        else
            seen_q <= seen_now;
    end

    // collected completion flags never drop inside a phase
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(clr) && !$past(rst) |-> ((seen_q & $past(seen_q)) == $past(seen_q))); // R2

endmodule

// File: rtl/gsc_reduce.sv
module gsc_reduce #(
    parameter int N_ENG = 4,
    parameter int RED_W = gsc_pkg::GSC_RED_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  gsc_pkg::red_op_e       op,
    input  logic [N_ENG*RED_W-1:0] vals,
    output logic [RED_W-1:0]       result,
    output logic                   valid
);
    import gsc_pkg::*;

    logic [RED_W-1:0] acc [0:N_ENG];

    assign acc[0] = '0;

    for (genvar i = 0; i < N_ENG; i++) begin : g_fold
        logic [RED_W-1:0] v;
        assign v = vals[i*RED_W +: RED_W];
        if (1) begin : g_stage
            always_comb begin
                if (op == RED_OR)
                    acc[i+1] = acc[i] | v;
                else
                    acc[i+1] = (v > acc[i]) ? v : acc[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= capture;
            if (capture)
                result <= acc[N_ENG];
        end
    end

    AST_RED_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R5

endmodule

// File: rtl/gsc_seq.sv
module gsc_seq #(
    parameter int N_ENG  = 4,
    parameter int STEP_W = 8,
    parameter int OPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STEP_W-1:0] step_count,
    input  logic              red_op_in,
    input  logic [OPC_W-1:0]  bcast_op_in,
    input  logic [N_ENG-1:0]  bcast_sel_in,
    input  logic              all_done,
    input  logic              barrier,
    output gsc_pkg::phase_e   phase,
    output logic              cmd_stb,
    output logic [STEP_W-1:0] step_no,
    output logic              busy,
    output logic              query_done,
    output gsc_pkg::red_op_e  red_op_q,
    output logic [OPC_W-1:0]  bcast_op_q,
    output logic [N_ENG-1:0]  bcast_sel_q,
    output logic              clr,
    output logic [N_ENG-1:0]  preset,
    output logic              capture
);
    import gsc_pkg::*;

    phase_e            nxt;
    logic [STEP_W-1:0] cnt_q;
    logic              accept;
    logic              phase_ok;

    assign accept   = (phase == PH_IDLE) && start;
    assign phase_ok = needs_drain(phase) ? barrier : all_done;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:     if (start) nxt = PH_BCAST;
            PH_BCAST:    if (phase_ok) nxt = (cnt_q == '0) ? PH_IDLE : PH_RECV;
            PH_RECV:     if (phase_ok) nxt = PH_UPDATE;
            PH_UPDATE:   if (phase_ok) nxt = (step_no == cnt_q) ? PH_SEND : PH_SENDRECV;
            PH_SENDRECV: if (phase_ok) nxt = PH_UPDATE;
            PH_SEND:     if (phase_ok) nxt = PH_IDLE;
            default:     nxt = PH_IDLE;
        endcase
    end

    assign clr     = (nxt != phase);
    assign preset  = (nxt == PH_BCAST) ? ~bcast_sel_in : '0;
    assign capture = is_rx_phase(phase) && barrier;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            cmd_stb     <= 1'b0;
            step_no     <= '0;
            busy        <= 1'b0;
            query_done  <= 1'b0;
            cnt_q       <= '0;
            red_op_q    <= RED_MAX;
            bcast_op_q  <= '0;
            bcast_sel_q <= '0;
        end else begin
            phase      <= nxt;
            cmd_stb    <= clr && (nxt != PH_IDLE);
            busy       <= (nxt != PH_IDLE);
            query_done <= (phase != PH_IDLE) && (nxt == PH_IDLE);
            if (accept) begin
                cnt_q       <= step_count;
                red_op_q    <= red_op_e'(red_op_in);
                bcast_op_q  <= bcast_op_in;
                bcast_sel_q <= bcast_sel_in;
                step_no     <= '0;
            end else if ((phase == PH_BCAST) && (nxt == PH_RECV)) begin
                step_no <= STEP_W'(1);
            end else if ((phase == PH_UPDATE) && (nxt == PH_SENDRECV)) begin
                step_no <= step_no + STEP_W'(1);
            end
        end
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step_no <= cnt_q)); // R6

    AST_UPDATE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_UPDATE) |=> (phase == PH_UPDATE) || (phase == PH_SEND)
                                 || (phase == PH_SENDRECV)); // R1

    AST_STB_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> (phase != PH_IDLE)); // R8

    AST_START_HELD: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$past(rst) |-> $stable(cnt_q)); // R7

endmodule

// File: rtl/graph_step_ctrl.sv
module graph_step_ctrl #(
    parameter int N_ENG  = 4,
    parameter int RED_W  = gsc_pkg::GSC_RED_W,
    parameter int STEP_W = 8,
    parameter int OPC_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [STEP_W-1:0]      step_count,
    input  logic                   red_op,
    input  logic [OPC_W-1:0]       bcast_op_in,
    input  logic [N_ENG-1:0]       bcast_sel_in,
    input  logic [N_ENG-1:0]       eng_done,
    input  logic                   net_empty,
    input  logic [N_ENG*RED_W-1:0] eng_red_val,
    output logic [2:0]             phase_cmd,
    output logic                   cmd_stb,
    output logic [OPC_W-1:0]       bcast_op,
    output logic [N_ENG-1:0]       bcast_sel,
    output logic                   busy,
    output logic [STEP_W-1:0]      step_no,
    output logic [RED_W-1:0]       red_result,
    output logic                   red_valid,
    output logic                   query_done
);
    import gsc_pkg::*;

    phase_e           phase;
    red_op_e          op_q;
    logic             all_done;
    logic             barrier;
    logic             clr;
    logic             capture;
    logic [N_ENG-1:0] preset;

    gsc_seq #(.N_ENG(N_ENG), .STEP_W(STEP_W), .OPC_W(OPC_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .step_count  (step_count),
        .red_op_in   (red_op),
        .bcast_op_in (bcast_op_in),
        .bcast_sel_in(bcast_sel_in),
        .all_done    (all_done),
        .barrier     (barrier),
        .phase       (phase),
        .cmd_stb     (cmd_stb),
        .step_no     (step_no),
        .busy        (busy),
        .query_done  (query_done),
        .red_op_q    (op_q),
        .bcast_op_q  (bcast_op),
        .bcast_sel_q (bcast_sel),
        .clr         (clr),
        .preset      (preset),
        .capture     (capture)
    );

    gsc_done_collect #(.N_ENG(N_ENG)) u_collect (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .preset   (preset),
        .eng_done (eng_done),
        .net_empty(net_empty),
        .all_done (all_done),
        .barrier  (barrier)
    );

    gsc_reduce #(.N_ENG(N_ENG), .RED_W(RED_W)) u_reduce (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .op     (op_q),
        .vals   (eng_red_val),
        .result (red_result),
        .valid  (red_valid)
    );

    assign phase_cmd = phase;

    // an update is entered from a drained receive only
    AST_DRAINED_BEFORE_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_UPDATE) && ($past(phase) != PH_UPDATE) |-> $past(net_empty)); // R2

    AST_RED_IN_UPDATE: assert property (@(posedge clk) disable iff (rst)
        red_valid |-> (phase == PH_UPDATE)); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        query_done |-> (phase == PH_IDLE) && !busy); // R9

    AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !busy); // R7

endmodule

// File: tb/graph_step_ctrl_test.sv
`timescale 1ns/1ps
module graph_step_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  step_count;
    logic        red_op;
    logic [3:0]  bcast_op_in;
    logic [3:0]  bcast_sel_in;
    logic [3:0]  eng_done;
    logic        net_empty;
    logic [63:0] eng_red_val;
    logic [2:0]  phase_cmd;
    logic        cmd_stb;
    logic [3:0]  bcast_op;
    logic [3:0]  bcast_sel;
    logic        busy;
    logic [7:0]  step_no;
    logic [15:0] red_result;
    logic        red_valid;
    logic        query_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    graph_step_ctrl uut (
        .clk(clk), .rst(rst), .start(start), .step_count(step_count),
        .red_op(red_op), .bcast_op_in(bcast_op_in), .bcast_sel_in(bcast_sel_in),
        .eng_done(eng_done), .net_empty(net_empty), .eng_red_val(eng_red_val),
        .phase_cmd(phase_cmd), .cmd_stb(cmd_stb), .bcast_op(bcast_op),
        .bcast_sel(bcast_sel), .busy(busy), .step_no(step_no),
        .red_result(red_result), .red_valid(red_valid), .query_done(query_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // check the phase seen now, then pulse done for one cycle
    task automatic step_phase(input logic [2:0] ph, input logic [7:0] stp, input logic stb,
                              input logic [3:0] dmask, input logic net, input string tag);
        chk({tag, " phase"}, 32'(phase_cmd), 32'(ph));
        chk({tag, " step"}, 32'(step_no), 32'(stp));
        chk({tag, " stb"}, 32'(cmd_stb), 32'(stb));
        eng_done  = dmask;
        net_empty = net;
        @(negedge clk);
        eng_done  = '0;
        net_empty = 1'b1;
    endtask

    task automatic issue_start(input logic [7:0] cnt, input logic op,
                               input logic [3:0] opc, input logic [3:0] sel);
        start = 1'b1; step_count = cnt; red_op = op; bcast_op_in = opc; bcast_sel_in = sel;
        @(negedge clk);
        start = 1'b0; bcast_op_in = '0; bcast_sel_in = '0;
    endtask

    task automatic t_reset;
        chk("R1 reset phase", 32'(phase_cmd), 0);
        chk("R7 reset busy", 32'(busy), 0);
        chk("R8 reset stb", 32'(cmd_stb), 0);
        chk("R5 reset valid", 32'(red_valid), 0);
        chk("R9 reset done", 32'(query_done), 0);
    endtask

    // three steps, max reduce, all engines broadcast
    task automatic t_full_query;
        issue_start(8'd3, 1'b0, 4'hA, 4'hF);
        chk("R7 busy after start", 32'(busy), 1);
        chk("R4 bcast op", 32'(bcast_op), 32'hA);
        chk("R4 bcast sel", 32'(bcast_sel), 32'hF);
        eng_red_val = {16'h0005, 16'h0300, 16'h00F0, 16'h0012};
        step_phase(3'd1, 8'd0, 1'b1, 4'hF, 1'b1, "R1 R6 bcast");
        step_phase(3'd2, 8'd1, 1'b1, 4'hF, 1'b1, "R1 recv s1");
        chk("R5 valid after barrier", 32'(red_valid), 1);
        chk("R5 max result", 32'(red_result), 32'h0300);
        eng_red_val = {16'h8001, 16'h0300, 16'h00F0, 16'h0012};
        step_phase(3'd3, 8'd1, 1'b1, 4'hF, 1'b0, "R3 update ignores net");
        chk("R5 valid one cycle", 32'(red_valid), 0);
        step_phase(3'd4, 8'd2, 1'b1, 4'hF, 1'b1, "R1 R6 sendrecv s2");
        chk("R5 max second step", 32'(red_result), 32'h8001);
        step_phase(3'd3, 8'd2, 1'b1, 4'hF, 1'b1, "R1 update s2");
        step_phase(3'd4, 8'd3, 1'b1, 4'hF, 1'b1, "R1 sendrecv s3");
        step_phase(3'd3, 8'd3, 1'b1, 4'hF, 1'b1, "R1 update s3");
        step_phase(3'd5, 8'd3, 1'b1, 4'hF, 1'b0, "R2 send waits net");
        step_phase(3'd5, 8'd3, 1'b0, 4'h0, 1'b1, "R2 R8 send sticky");
        chk("R1 back to idle", 32'(phase_cmd), 0);
        chk("R7 busy low at end", 32'(busy), 0);
        chk("R9 done pulse", 32'(query_done), 1);
        @(negedge clk);
        chk("R9 done one cycle", 32'(query_done), 0);
        chk("R8 no stb idle", 32'(cmd_stb), 0);
    endtask

    // one step, OR reduce, partial broadcast, split barrier, ignored start
    task automatic t_barrier_subset;
        issue_start(8'd1, 1'b1, 4'h3, 4'b0101);
        chk("R4 subset sel", 32'(bcast_sel), 32'h5);
        step_phase(3'd1, 8'd0, 1'b1, 4'b0101, 1'b1, "R4 subset ack");
        eng_red_val = {16'h0005, 16'h0300, 16'h00F0, 16'h0012};
        step_phase(3'd2, 8'd1, 1'b1, 4'b0011, 1'b1, "R2 partial done");
        start = 1'b1; step_count = 8'd5;
        step_phase(3'd2, 8'd1, 1'b0, 4'b1100, 1'b0, "R2 R7 net busy");
        start = 1'b0;
        chk("R5 no valid without barrier", 32'(red_valid), 0);
        step_phase(3'd2, 8'd1, 1'b0, 4'b0000, 1'b1, "R2 held by net");
        chk("R5 valid OR", 32'(red_valid), 1);
        chk("R5 OR result", 32'(red_result), 32'h03F7);
        step_phase(3'd3, 8'd1, 1'b1, 4'hF, 1'b1, "R2 update after sticky");
        step_phase(3'd5, 8'd1, 1'b1, 4'hF, 1'b1, "R7 start ignored count kept");
        chk("R9 done subset", 32'(query_done), 1);
        chk("R7 idle subset", 32'(busy), 0);
        @(negedge clk);
    endtask

    // zero steps: broadcast only
    task automatic t_zero_steps;
        issue_start(8'd0, 1'b0, 4'h7, 4'hF);
        step_phase(3'd1, 8'd0, 1'b1, 4'b0111, 1'b1, "R4 missing ack holds");
        step_phase(3'd1, 8'd0, 1'b0, 4'b1000, 1'b0, "R6 bcast");
        chk("R6 zero steps idle", 32'(phase_cmd), 0);
        chk("R6 zero steps done", 32'(query_done), 1);
        chk("R5 no reduce zero steps", 32'(red_valid), 0);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; step_count = '0; red_op = 1'b0;
        bcast_op_in = '0; bcast_sel_in = '0; eng_done = '0; net_empty = 1'b1;
        eng_red_val = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_query();
        t_barrier_subset();
        t_zero_steps();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule